// File: doc/BRIEF.md
# UART Automatic RTS/CTS Flow Control

This block sits beside a UART channel's FIFOs and shifters and handles hardware handshaking with the remote device. Both handshake wires are active low. On the receive side, a small state machine compares the RX FIFO occupancy with a 4-bit programmable trigger level. It drives `rts_n` low while there is room and releases it (drives it high) when the occupancy reaches the level. On the transmit side, a second state machine gives the transmitter permission to begin each new character. It does so only while a synchronized `cts_n` is asserted, and it never interrupts a character that has already started.

`cts_n` passes through a two-flop synchronizer. Any change of the synchronized level sets a sticky change flag, which software clears by writing one. When either auto feature is switched off, the block falls back to a manual behaviour. In manual RTS mode, `rts_n` follows a software bit. In manual CTS mode, transmission ignores `cts_n`. The FIFOs, the shift registers and the baud generator are outside this block.

The RTS machine has two states. RTS_ASSERT drives `rts_n` low. RTS_RELEASE drives `rts_n` high and is the reset state. With auto RTS enabled, RTS_ASSERT goes to RTS_RELEASE when the count equals the trigger level, and RTS_RELEASE goes to RTS_ASSERT when the count falls below the level. With auto RTS disabled, the next state is RTS_ASSERT when the software bit is 1 and RTS_RELEASE otherwise.

The TX machine has three states: TX_IDLE, TX_LAUNCH and TX_ACTIVE. TX_IDLE goes to TX_LAUNCH when data is pending and clear-to-send holds, or when auto CTS is off. TX_LAUNCH goes to TX_ACTIVE unconditionally, and `tx_start` is high only in TX_LAUNCH. TX_ACTIVE goes back to TX_IDLE on `tx_done`.

Top module: `uart_flowctl`

## Requirements
- R1: While `rst_n` is low, `rts_n` is 1, `tx_start` is 0, `cts_chg` is 0 and `cts_asserted` is 0.
- R2: With `auto_rts_en`=1 and `rx_count` below `rts_trig`, `rts_n` is 0 one clock after the inputs are applied.
- R3: With auto RTS enabled and `rts_n` low, `rts_n` goes high one clock after `rx_count` equals `rts_trig`. A count that is above the level without having equalled it does not release `rts_n`.
- R4: Once released in auto mode, `rts_n` stays high while `rx_count` is greater than or equal to `rts_trig`. It returns low one clock after `rx_count` drops below `rts_trig`.
- R5: With `auto_rts_en`=0, `rts_n` equals the inverse of `sw_rts`, one clock later, whatever `rx_count` is.
- R6: With `auto_cts_en`=1, `tx_start` stays 0 while the synchronized `cts_n` is high. It pulses three clocks after `cts_n` falls, provided `tx_pending` is 1.
- R7: `tx_start` is a single-cycle pulse, and no further pulse occurs until `tx_done` has been seen.
- R8: A rise of `cts_n` after `tx_start` does not affect the character in progress. After `tx_done`, the next `tx_start` again waits for an asserted, synchronized `cts_n`.
- R9: With `auto_cts_en`=0, `tx_start` pulses one clock after `tx_pending` is seen in idle, regardless of `cts_n`.
- R10: `cts_chg` becomes 1 after any rising or falling edge of the synchronized `cts_n` and stays 1 until a one-cycle `cts_chg_clr` pulse clears it.
- R11: `cts_asserted` equals the inverse of `cts_n` as it was two clocks earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| auto_rts_en | input | 1 | 1: RTS driven from RX level; 0: from `sw_rts` |
| auto_cts_en | input | 1 | 1: transmission gated by CTS |
| sw_rts | input | 1 | Software RTS request (1 = assert) in manual mode |
| rts_trig | input | 4 | RX count at which RTS is released |
| rx_count | input | CNT_W (7) | Current RX FIFO occupancy |
| rts_n | output | 1 | Request-to-send, active low |
| cts_n | input | 1 | Clear-to-send from the remote device, active low, asynchronous |
| cts_chg_clr | input | 1 | Write-one clear of `cts_chg` |
| cts_asserted | output | 1 | Synchronized CTS level, 1 = asserted |
| cts_chg | output | 1 | Sticky flag: synchronized CTS changed |
| tx_pending | input | 1 | TX FIFO not empty |
| tx_done | input | 1 | Pulse from transmitter: character finished |
| tx_start | output | 1 | One-cycle permission to start the next character |

## Verification
A wrong RTS state shows on `rts_n` within one clock, because the pin is decoded straight from the state register. The directed tests therefore hold each count pattern and check the pin one clock later. A TX machine stuck in TX_LAUNCH, or one that skips TX_ACTIVE, appears as a `tx_start` that stays high or repeats before `tx_done`. A broken synchronizer shows as `tx_start` or `cts_asserted` arriving a clock early or late relative to the `cts_n` edge.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;

    typedef enum logic [0:0] {
        RTS_ASSERT  = 1'b0,
        RTS_RELEASE = 1'b1
    } rts_state_e;

    typedef enum logic [1:0] {
        TX_IDLE   = 2'd0,
        TX_LAUNCH = 2'd1,
        TX_ACTIVE = 2'd2
    } tx_state_e;

endpackage

// File: rtl/uart_fc_cts_sync.sv
module uart_fc_cts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_n,
    input  logic chg_clr,
    output logic cts_ok,
    output logic cts_chg
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;
    logic              chg_q;
    logic              edge_seen;

    // synchronizer chain, resets to "not clear to send"
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            last_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], cts_n};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign edge_seen = sync_q[STAGES-1] ^ last_q;

    // sticky change flag, a new edge wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chg_q <= 1'b0;
        else if (edge_seen) chg_q <= 1'b1;
        else if (chg_clr) chg_q <= 1'b0;
    end

    assign cts_ok  = ~sync_q[STAGES-1];
    assign cts_chg = chg_q;

    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_chg && !chg_clr) |=> cts_chg);

    a_r10_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cts_ok) |=> cts_chg);

endmodule

// File: rtl/uart_fc_rts_ctl.sv
module uart_fc_rts_ctl
    import uart_fc_pkg::*;
#(
    parameter int CNT_W = 7,
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_en,
    input  logic             sw_assert,
    input  logic [LVL_W-1:0] trig,
    input  logic [CNT_W-1:0] rx_count,
    output logic             rts_n
);
    localparam int PAD = CNT_W - LVL_W;

    rts_state_e       state_q, state_d;
    logic [CNT_W-1:0] trig_ext;

    assign trig_ext = {{PAD{1'b0}}, trig};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RTS_RELEASE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!auto_en) begin
            state_d = sw_assert ? RTS_ASSERT : RTS_RELEASE;
        end else begin
            unique case (state_q)
                RTS_ASSERT:  if (rx_count == trig_ext) state_d = RTS_RELEASE;
                RTS_RELEASE: if (rx_count <  trig_ext) state_d = RTS_ASSERT;
                default:     state_d = RTS_RELEASE;
            endcase
        end
    end

    // outputs
    always_comb begin
        rts_n = (state_q == RTS_RELEASE);
    end

    a_r3_release_at_level: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && !rts_n && rx_count == trig_ext) |=> rts_n);

    a_r2_hold_asserted: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && !rts_n && rx_count != trig_ext) |=> !rts_n);

    a_r4_hold_released: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && rts_n && rx_count >= trig_ext) |=> rts_n);

    a_r5_manual_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |=> (rts_n == !$past(sw_assert)));

endmodule

// File: rtl/uart_fc_tx_gate.sv
module uart_fc_tx_gate
    import uart_fc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic cts_ok,
    input  logic tx_pending,
    input  logic tx_done,
    output logic tx_start
);
    tx_state_e state_q, state_d;
    logic      may_send;

    assign may_send = cts_ok | ~auto_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:   if (tx_pending && may_send) state_d = TX_LAUNCH;
            TX_LAUNCH: state_d = TX_ACTIVE;
            TX_ACTIVE: if (tx_done) state_d = TX_IDLE;
            default:   state_d = TX_IDLE;
        endcase
    end

    always_comb begin
        tx_start = (state_q == TX_LAUNCH);
    end

    a_r6_gated_by_cts: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> $past(cts_ok || !auto_en));

    a_r7_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);

    a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_ACTIVE && !tx_done) |=> !tx_start);

endmodule

// File: rtl/uart_flowctl.sv
module uart_flowctl
    import uart_fc_pkg::*;
#(
    parameter int CNT_W       = 7,
    parameter int LVL_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_rts_en,
    input  logic             auto_cts_en,
    input  logic             sw_rts,
    input  logic [LVL_W-1:0] rts_trig,
    input  logic [CNT_W-1:0] rx_count,
    output logic             rts_n,
    input  logic             cts_n,
    input  logic             cts_chg_clr,
    output logic             cts_asserted,
    output logic             cts_chg,
    input  logic             tx_pending,
    input  logic             tx_done,
    output logic             tx_start
);
    logic cts_ok;

    uart_fc_rts_ctl #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_rts (
        .clk       (clk),
        .rst_n     (rst_n),
        .auto_en   (auto_rts_en),
        .sw_assert (sw_rts),
        .trig      (rts_trig),
        .rx_count  (rx_count),
        .rts_n     (rts_n)
    );

    uart_fc_cts_sync #(.STAGES(SYNC_STAGES)) u_cts (
        .clk     (clk),
        .rst_n   (rst_n),
        .cts_n   (cts_n),
        .chg_clr (cts_chg_clr),
        .cts_ok  (cts_ok),
        .cts_chg (cts_chg)
    );

    uart_fc_tx_gate u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .auto_en    (auto_cts_en),
        .cts_ok     (cts_ok),
        .tx_pending (tx_pending),
        .tx_done    (tx_done),
        .tx_start   (tx_start)
    );

    assign cts_asserted = cts_ok;

    a_r11_sync_level: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(cts_n) |=> ##1 (cts_asserted == !$past(cts_n, 2)));

endmodule

// File: tb/sim_uart_flowctl.sv
`timescale 1ns/1ps
module sim_uart_flowctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       auto_rts_en = 1'b1;
    logic       auto_cts_en = 1'b1;
    logic       sw_rts = 1'b0;
    logic [3:0] rts_trig = 4'd8;
    logic [6:0] rx_count = 7'd0;
    logic       rts_n;
    logic       cts_n = 1'b1;
    logic       cts_chg_clr = 1'b0;
    logic       cts_asserted;
    logic       cts_chg;
    logic       tx_pending = 1'b0;
    logic       tx_done = 1'b0;
    logic       tx_start;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    uart_flowctl u0 (
        .clk(clk), .rst_n(rst_n), .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en),
        .sw_rts(sw_rts), .rts_trig(rts_trig), .rx_count(rx_count), .rts_n(rts_n),
        .cts_n(cts_n), .cts_chg_clr(cts_chg_clr), .cts_asserted(cts_asserted),
        .cts_chg(cts_chg), .tx_pending(tx_pending), .tx_done(tx_done), .tx_start(tx_start)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic done_pulse();
        tx_done = 1'b1;
        cyc(1);
        tx_done = 1'b0;
    endtask

    task automatic t_reset();
        cyc(2);
        chk("R1", "rts_n in reset", rts_n, 1);
        chk("R1", "tx_start in reset", tx_start, 0);
        chk("R1", "cts_chg in reset", cts_chg, 0);
        chk("R1", "cts_asserted in reset", cts_asserted, 0);
        rst_n = 1'b1;
        cyc(1);
    endtask

    task automatic t_rts_auto();
        auto_rts_en = 1'b1; rts_trig = 4'd8;
        rx_count = 7'd3; cyc(1);
        chk("R2", "rts_n below level", rts_n, 0);
        rx_count = 7'd12; cyc(2);
        chk("R3", "rts_n count skipped past level", rts_n, 0);
        rx_count = 7'd8; cyc(1);
        chk("R3", "rts_n at level", rts_n, 1);
        rx_count = 7'd9; cyc(2);
        chk("R4", "rts_n above level", rts_n, 1);
        rx_count = 7'd8; cyc(1);
        chk("R4", "rts_n back at level", rts_n, 1);
        rx_count = 7'd7; cyc(1);
        chk("R4", "rts_n below level again", rts_n, 0);
        rts_trig = 4'd15; rx_count = 7'd15; cyc(1);
        chk("R3", "rts_n at max level", rts_n, 1);
        rx_count = 7'd0; rts_trig = 4'd8; cyc(1);
        chk("R2", "rts_n empty fifo", rts_n, 0);
    endtask

    task automatic t_rts_manual();
        auto_rts_en = 1'b0; sw_rts = 1'b1; rx_count = 7'd8; cyc(1);
        chk("R5", "manual assert ignores count", rts_n, 0);
        sw_rts = 1'b0; rx_count = 7'd0; cyc(1);
        chk("R5", "manual release", rts_n, 1);
        auto_rts_en = 1'b1; cyc(1);
    endtask

    task automatic t_cts_gate();
        auto_cts_en = 1'b1; cts_n = 1'b1; tx_pending = 1'b1;
        cyc(5);
        chk("R6", "no start without cts", tx_start, 0);
        chk("R11", "cts_asserted while high", cts_asserted, 0);
        cts_n = 1'b0;
        cyc(1);
        chk("R11", "cts_asserted after one clock", cts_asserted, 0);
        cyc(1);
        chk("R11", "cts_asserted after two clocks", cts_asserted, 1);
        chk("R6", "no start before sync+decide", tx_start, 0);
        cyc(1);
        chk("R6", "start three clocks after cts", tx_start, 1);
        cyc(1);
        chk("R7", "start is one cycle", tx_start, 0);
        cyc(4);
        chk("R7", "no restart before done", tx_start, 0);
    endtask

    task automatic t_midframe();
        int seen = 0;
        cts_n = 1'b1;
        cyc(4);
        chk("R8", "no start mid-frame after cts rise", tx_start, 0);
        done_pulse();
        for (int i = 0; i < 5; i++) begin
            if (tx_start) seen++;
            cyc(1);
        end
        chk("R8", "next start waits for cts", seen, 0);
        cts_n = 1'b0;
        cyc(3);
        chk("R8", "start after cts returns", tx_start, 1);
        tx_pending = 1'b0;
        cyc(1);
        done_pulse();
    endtask

    task automatic t_cts_ignore();
        auto_cts_en = 1'b0; cts_n = 1'b1;
        cyc(3);
        tx_pending = 1'b1;
        cyc(1);
        chk("R9", "start with cts high in manual", tx_start, 1);
        tx_pending = 1'b0;
        cyc(1);
        done_pulse();
        auto_cts_en = 1'b1;
    endtask

    task automatic t_chg();
        cts_chg_clr = 1'b1; cyc(1); cts_chg_clr = 1'b0; cyc(1);
        chk("R10", "flag cleared by write-one", cts_chg, 0);
        cts_n = 1'b0; cyc(4);
        chk("R10", "flag set on falling cts", cts_chg, 1);
        cyc(3);
        chk("R10", "flag sticky", cts_chg, 1);
        cts_chg_clr = 1'b1; cyc(1); cts_chg_clr = 1'b0;
        chk("R10", "flag cleared", cts_chg, 0);
        cts_n = 1'b1; cyc(4);
        chk("R10", "flag set on rising cts", cts_chg, 1);
    endtask

    initial begin
        t_reset();
        t_rts_auto();
        t_rts_manual();
        t_cts_gate();
        t_midframe();
        t_cts_ignore();
        t_chg();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule